// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counter with a companion 16-bit hold register. While running, the counter advances either on a prescaled oscillator enable or on falling edges of an external count pin. When it wraps past all-ones, it does one of three things, depending on the operating mode. In reload mode it sets a sticky overflow flag and loads the hold value. In capture mode it sets the flag and rolls over to zero. In baud mode it loads the hold value and emits a one-cycle tick for a serial transmitter and receiver, and the overflow flag is left alone.

A second external pin acts as a trigger. When triggering is enabled, a falling edge on it copies the count into the hold register in capture mode, or forces a reload in reload mode. It also sets a sticky trigger flag. Software reaches the block through a byte-wide write port. Through this port it loads either byte of the counter or of the hold register, sets the control bits, and overwrites the two flags.

The operating mode is held in a small state machine that is updated together with the control register. There are four states:
- HALT: the run bit is clear.
- RELOAD: running with neither baud select nor capture set.
- CAPTURE: running with capture set and no baud select.
- BAUD: running with either baud select set.

Every control write moves the machine to the state that the new control value selects. The transitions are named by their target: to-HALT, to-RELOAD, to-CAPTURE and to-BAUD.

Top module: `capreload_timer`

## Requirements
- R1: After reset the count, the hold value, the control bits and both flags are zero, and baud_tick is low.
- R2: While the run bit is clear, the count does not change on osc_tick or on pin edges, except through register writes.
- R3: In RELOAD or CAPTURE with the oscillator source selected, the count advances by one on every 12th osc_tick pulse. The first step lands 12 clocks after the clock edge that sets the run bit, when osc_tick is held high.
- R4: When either baud select is set (control bit 3 transmit, bit 4 receive), the oscillator prescale is 2 instead of 12. An overflow raises baud_tick for exactly one cycle, on the edge that reloads the count. An overflow in this mode never sets ovf_flag.
- R5: In RELOAD and BAUD, an overflow loads the count from the hold register. In RELOAD it also sets ovf_flag on the same edge.
- R6: In CAPTURE, an overflow wraps the count to zero, sets ovf_flag and leaves the hold value unchanged.
- R7: With the external-count bit (control bit 1) set, osc_tick is ignored and the count advances once per falling edge of cnt_pin. The change appears on the third clock edge after the pin is sampled low. Rising edges do nothing.
- R8: In CAPTURE with trigger enable (control bit 5) set, a falling edge on trig_pin copies the count into the hold register and sets trig_flag. The change appears on the third clock edge after the pin is sampled low.
- R9: In RELOAD with trigger enable set, a falling edge on trig_pin loads the count from the hold register and sets trig_flag, with the same latency as R8.
- R10: A trig_pin falling edge changes nothing in three cases: when trigger enable is clear, in BAUD, or in HALT.
- R11: ovf_flag (flag bit 0) and trig_flag (flag bit 1) stay set until a write to the flag register replaces them. A hardware set in the same cycle as that write wins.
- R12: A write to a byte of the count or of the hold register takes priority over a same-cycle step, reload or capture. The written byte takes the new data and the other byte keeps its old value.
- R13: The write port selects registers through wr_sel:
  - 0: count low byte
  - 1: count high byte
  - 2: hold low byte
  - 3: hold high byte
  - 4: control
  - 5: flags

  Control bit 0 is run and bit 2 is capture. A write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One pulse per oscillator period |
| cnt_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous external trigger input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R13) |
| wr_data | input | 8 | Write data |
| ovf_flag | output | 1 | Sticky overflow flag |
| trig_flag | output | 1 | Sticky trigger flag |
| baud_tick | output | 1 | One-cycle pulse on overflow in baud mode |
| count_val | output | 16 | Current count |
| hold_val | output | 16 | Current hold (reload/capture) value |

## Verification
The hardest situation to reach is a software byte write that lands on the same edge as a counter step. The step is only visible three synchronizer edges after the pin moves. The bench therefore drops cnt_pin at a known negative edge and issues the count write exactly two clocks later, so that both hit the same rising edge. It then expects the written byte with the other byte unincremented. Overflow in each mode is reached cheaply by preloading the count a few steps below all-ones before setting the run bit.

// File: rtl/cr_timer_pkg.sv
`timescale 1ns/1ps
package cr_timer_pkg;

    typedef enum logic [1:0] {
        S_HALT    = 2'd0,
        S_RELOAD  = 2'd1,
        S_CAPTURE = 2'd2,
        S_BAUD    = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        SEL_CNT_LO  = 3'd0,
        SEL_CNT_HI  = 3'd1,
        SEL_HOLD_LO = 3'd2,
        SEL_HOLD_HI = 3'd3,
        SEL_CTRL    = 3'd4,
        SEL_FLAGS   = 3'd5
    } reg_sel_e;

    localparam int CTL_W    = 6;
    localparam int FLG_OVF  = 0;
    localparam int FLG_TRIG = 1;

    // bit 0 run ... bit 5 trigger enable
    typedef struct packed {
        logic trig_en;
        logic rx_baud;
        logic tx_baud;
        logic capture;
        logic ext_count;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic step_en;
        logic fast_div;
        logic ovf_flags;
        logic ovf_reload;
        logic ovf_baud;
        logic trig_capture;
        logic trig_reload;
    } mode_act_t;

endpackage

// File: rtl/cr_pin_edge.sv
`timescale 1ns/1ps
module cr_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Idle-high reset so that release of reset never looks like an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/cr_prescaler.sv
`timescale 1ns/1ps
module cr_prescaler #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fast_i,
    input  logic osc_tick_i,
    output logic step_o
);

    localparam int            PW       = $clog2(DIV_SLOW);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] lim;
    logic          at_lim;

    assign lim    = fast_i ? LIM_FAST : LIM_SLOW;
    // >= so a switch from slow to fast with a large phase wraps at once
    assign at_lim = (ph_q >= lim);
    assign step_o = en_i & osc_tick_i & at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (!en_i) begin
            ph_q <= '0;
        end else if (osc_tick_i) begin
            ph_q <= at_lim ? '0 : ph_q + PW'(1);
        end
    end

endmodule

// File: rtl/cr_mode_fsm.sv
`timescale 1ns/1ps
module cr_mode_fsm
    import cr_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctrl_t     ctrl_d_i,
    output mode_e     mode_o,
    output mode_act_t act_o
);

    mode_e state_q;
    mode_e state_d;

    // Next state follows the control value being written this cycle
    always_comb begin
        if (!ctrl_d_i.run) begin
            state_d = S_HALT;
        end else if (ctrl_d_i.tx_baud | ctrl_d_i.rx_baud) begin
            state_d = S_BAUD;
        end else if (ctrl_d_i.capture) begin
            state_d = S_CAPTURE;
        end else begin
            state_d = S_RELOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        act_o = '0;
        unique case (state_q)
            S_HALT: begin
                act_o = '0;
            end
            S_RELOAD: begin
                act_o.step_en     = 1'b1;
                act_o.ovf_flags   = 1'b1;
                act_o.ovf_reload  = 1'b1;
                act_o.trig_reload = 1'b1;
            end
            S_CAPTURE: begin
                act_o.step_en      = 1'b1;
                act_o.ovf_flags    = 1'b1;
                act_o.trig_capture = 1'b1;
            end
            S_BAUD: begin
                act_o.step_en    = 1'b1;
                act_o.fast_div   = 1'b1;
                act_o.ovf_reload = 1'b1;
                act_o.ovf_baud   = 1'b1;
            end
            default: act_o = '0;
        endcase
    end

    assign mode_o = state_q;

endmodule

// File: rtl/capreload_timer.sv
`timescale 1ns/1ps
module capreload_timer
    import cr_timer_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int DIV_NORMAL  = 12,
    parameter int DIV_BAUD    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick,
    input  logic                cnt_pin,
    input  logic                trig_pin,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                ovf_flag,
    output logic                trig_flag,
    output logic                baud_tick,
    output logic [2*BYTE_W-1:0] count_val,
    output logic [2*BYTE_W-1:0] hold_val
);

    localparam int               CNT_W   = 2 * BYTE_W;
    localparam int               NPIN    = 2;
    localparam int               PIN_CNT = 0;
    localparam int               PIN_TRG = 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // ---------------- pin synchronizers ----------------
    logic [NPIN-1:0] pins_async;
    logic [NPIN-1:0] pin_fall;

    assign pins_async = {trig_pin, cnt_pin};

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        cr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pins_async[gi]),
            .fall_o    (pin_fall[gi])
        );
    end

    // ---------------- write decode ----------------
    reg_sel_e sel;
    logic     wr_cnt_lo, wr_cnt_hi, wr_hold_lo, wr_hold_hi, wr_ctrl, wr_flags;

    assign sel        = reg_sel_e'(wr_sel);
    assign wr_cnt_lo  = wr_en && (sel == SEL_CNT_LO);
    assign wr_cnt_hi  = wr_en && (sel == SEL_CNT_HI);
    assign wr_hold_lo = wr_en && (sel == SEL_HOLD_LO);
    assign wr_hold_hi = wr_en && (sel == SEL_HOLD_HI);
    assign wr_ctrl    = wr_en && (sel == SEL_CTRL);
    assign wr_flags   = wr_en && (sel == SEL_FLAGS);

    // ---------------- control and mode ----------------
    ctrl_t     ctrl_q, ctrl_d;
    mode_e     mode_q;
    mode_act_t act;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d = ctrl_t'(wr_data[CTL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    cr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_d_i (ctrl_d),
        .mode_o   (mode_q),
        .act_o    (act)
    );

    // ---------------- step source ----------------
    logic presc_step, step, ovf_evt, trig_evt, do_capture, do_trig_reload;

    cr_prescaler #(.DIV_SLOW(DIV_NORMAL), .DIV_FAST(DIV_BAUD)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (act.step_en & ~ctrl_q.ext_count),
        .fast_i     (act.fast_div),
        .osc_tick_i (osc_tick),
        .step_o     (presc_step)
    );

    logic [CNT_W-1:0] cnt_q, cnt_d, hold_q, hold_d;

    assign step           = act.step_en & (ctrl_q.ext_count ? pin_fall[PIN_CNT] : presc_step);
    assign ovf_evt        = step & (cnt_q == CNT_MAX);
    assign trig_evt       = pin_fall[PIN_TRG] & ctrl_q.trig_en;
    assign do_capture     = trig_evt & act.trig_capture;
    assign do_trig_reload = trig_evt & act.trig_reload;

    // ---------------- count and hold ----------------
    always_comb begin
        cnt_d = cnt_q;
        if (wr_cnt_lo | wr_cnt_hi) begin
            if (wr_cnt_lo) cnt_d[BYTE_W-1:0]     = wr_data;
            if (wr_cnt_hi) cnt_d[CNT_W-1:BYTE_W] = wr_data;
        end else if ((ovf_evt & act.ovf_reload) | do_trig_reload) begin
            cnt_d = hold_q;
        end else if (step) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        hold_d = hold_q;
        if (wr_hold_lo | wr_hold_hi) begin
            if (wr_hold_lo) hold_d[BYTE_W-1:0]     = wr_data;
            if (wr_hold_hi) hold_d[CNT_W-1:BYTE_W] = wr_data;
        end else if (do_capture) begin
            hold_d = cnt_q;
        end
    end

    // ---------------- flags and tick ----------------
    logic ovf_q, ovf_d, trg_q, trg_d, baud_q;

    always_comb begin
        ovf_d = wr_flags ? wr_data[FLG_OVF] : ovf_q;
        if (ovf_evt & act.ovf_flags) ovf_d = 1'b1;
        trg_d = wr_flags ? wr_data[FLG_TRIG] : trg_q;
        if (do_capture | do_trig_reload) trg_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
            ovf_q  <= 1'b0;
            trg_q  <= 1'b0;
            baud_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
            ovf_q  <= ovf_d;
            trg_q  <= trg_d;
            baud_q <= ovf_evt & act.ovf_baud;
        end
    end

    assign count_val = cnt_q;
    assign hold_val  = hold_q;
    assign ovf_flag  = ovf_q;
    assign trig_flag = trg_q;
    assign baud_tick = baud_q;

endmodule

// File: rtl/cr_timer_chk.sv
`timescale 1ns/1ps
module cr_timer_chk
    import cr_timer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_sel,
    input logic [BYTE_W-1:0]   wr_data,
    input mode_e               mode_i,
    input logic                step_i,
    input logic [2*BYTE_W-1:0] count_i,
    input logic [2*BYTE_W-1:0] hold_i,
    input logic                ovf_i,
    input logic                baud_i
);

    localparam int CNT_W = 2 * BYTE_W;

    logic cnt_wr, flag_wr, wraps;

    assign cnt_wr  = wr_en && ((wr_sel == 3'(SEL_CNT_LO)) || (wr_sel == 3'(SEL_CNT_HI)));
    assign flag_wr = wr_en && (wr_sel == 3'(SEL_FLAGS));
    assign wraps   = step_i && (count_i == {CNT_W{1'b1}}) && !cnt_wr;

    AST_BAUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_i |=> !baud_i); // R4

    AST_BAUD_ONLY_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        baud_i |-> $past(mode_i == S_BAUD)); // R4

    AST_BAUD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == S_BAUD && !flag_wr && !ovf_i) |=> !ovf_i); // R4

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == S_HALT && !cnt_wr) |=> $stable(count_i)); // R2

    AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (wraps && (mode_i == S_RELOAD || mode_i == S_BAUD)) |=> (count_i == $past(hold_i))); // R5

    AST_CAPTURE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wraps && mode_i == S_CAPTURE) |=> (count_i == '0 && ovf_i)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !flag_wr) |=> ovf_i); // R11

    AST_LOW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'(SEL_CNT_LO)) |=> (count_i[BYTE_W-1:0] == $past(wr_data))); // R12

endmodule

bind capreload_timer cr_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mode_i  (mode_q),
    .step_i  (step),
    .count_i (count_val),
    .hold_i  (hold_val),
    .ovf_i   (ovf_flag),
    .baud_i  (baud_tick)
);

// File: tb/capreload_timer_tb_top.sv
`timescale 1ns/1ps
module capreload_timer_tb_top;

    localparam int SIG_CNT  = 0;
    localparam int SIG_HOLD = 1;
    localparam int SIG_OVF  = 2;
    localparam int SIG_TRIG = 3;
    localparam int SIG_BAUD = 4;

    // register map and control bits per R13, R4, R7, R8
    localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_HLO = 3'd2, A_HHI = 3'd3,
                           A_CTL = 3'd4, A_FLG = 3'd5;
    localparam logic [7:0] C_RUN = 8'h01, C_EXT = 8'h02, C_CAP = 8'h04,
                           C_TXB = 8'h08, C_RXB = 8'h10, C_TRG = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        cnt_pin = 1'b1;
    logic        trig_pin = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        ovf_flag, trig_flag, baud_tick;
    logic [15:0] count_val, hold_val;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        int          sig;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    capreload_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .cnt_pin   (cnt_pin),
        .trig_pin  (trig_pin),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ovf_flag  (ovf_flag),
        .trig_flag (trig_flag),
        .baud_tick (baud_tick),
        .count_val (count_val),
        .hold_val  (hold_val)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] actual_of(input int sig);
        case (sig)
            SIG_CNT:  return count_val;
            SIG_HOLD: return hold_val;
            SIG_OVF:  return {15'd0, ovf_flag};
            SIG_TRIG: return {15'd0, trig_flag};
            default:  return {15'd0, baud_tick};
        endcase
    endfunction

    // monitor: compares every due item away from the rising edge
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at <= cyc) begin
                logic [15:0] act;
                act = actual_of(sb_q[i].sig);
                checks++;
                if (act !== sb_q[i].exp || sb_q[i].at != cyc) begin
                    errors++;
                    $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h",
                             sb_q[i].tag, sb_q[i].sig, cyc, act, sb_q[i].exp);
                end
                sb_q.delete(i);
            end
        end
    end

    // driver side: dly counted in clock edges from the current negedge
    task automatic expect_in(input int dly, input int sig, input logic [15:0] v, input string tag);
        exp_t it;
        it.at = cyc + dly; it.sig = sig; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(A_CLO, v[7:0]); wr(A_CHI, v[15:8]);
    endtask

    task automatic set_hold(input logic [15:0] v);
        wr(A_HLO, v[7:0]); wr(A_HHI, v[15:8]);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        expect_in(1, SIG_CNT, 16'h0, "R1");
        expect_in(1, SIG_HOLD, 16'h0, "R1");
        expect_in(1, SIG_OVF, 16'h0, "R1");
        expect_in(1, SIG_TRIG, 16'h0, "R1");
        expect_in(1, SIG_BAUD, 16'h0, "R1");
        drain();

        // R2 halted with oscillator running
        osc_tick = 1'b1;
        set_cnt(16'hFFF0);
        set_hold(16'h1234);
        expect_in(20, SIG_CNT, 16'hFFF0, "R2");
        drain();

        // R3 / R5 normal timer, reload on overflow
        expect_in(12, SIG_CNT, 16'hFFF0, "R3");
        expect_in(13, SIG_CNT, 16'hFFF1, "R3");
        expect_in(192, SIG_CNT, 16'hFFFF, "R3");
        expect_in(192, SIG_OVF, 16'h0, "R5");
        expect_in(193, SIG_CNT, 16'h1234, "R5");
        expect_in(193, SIG_OVF, 16'h1, "R5");
        wr(A_CTL, C_RUN);
        drain();
        wr(A_CTL, 8'h00);

        // R11 sticky, then cleared by a flag write
        expect_in(4, SIG_OVF, 16'h1, "R11");
        drain();
        expect_in(1, SIG_OVF, 16'h0, "R11");
        wr(A_FLG, 8'h00);
        drain();

        // R4 transmit baud: prescale 2, tick, reload, no flag
        set_cnt(16'hFFFE);
        set_hold(16'hABCD);
        expect_in(2, SIG_CNT, 16'hFFFE, "R4");
        expect_in(3, SIG_CNT, 16'hFFFF, "R4");
        expect_in(4, SIG_BAUD, 16'h0, "R4");
        expect_in(5, SIG_CNT, 16'hABCD, "R4");
        expect_in(5, SIG_BAUD, 16'h1, "R4");
        expect_in(6, SIG_BAUD, 16'h0, "R4");
        expect_in(7, SIG_OVF, 16'h0, "R4");
        wr(A_CTL, C_RUN | C_TXB);
        drain();
        wr(A_CTL, 8'h00);

        // R4 receive baud alone also uses prescale 2
        set_cnt(16'h0000);
        expect_in(3, SIG_CNT, 16'h0001, "R4");
        expect_in(5, SIG_CNT, 16'h0002, "R4");
        wr(A_CTL, C_RUN | C_RXB);
        drain();
        wr(A_CTL, 8'h00);

        // R7 external count, R6 capture-mode wrap
        set_cnt(16'hFFFE);
        set_hold(16'h1111);
        wr(A_CTL, C_RUN | C_EXT | C_CAP);
        expect_in(10, SIG_CNT, 16'hFFFE, "R7");
        drain();
        cnt_pin = 1'b0;
        expect_in(2, SIG_CNT, 16'hFFFE, "R7");
        expect_in(3, SIG_CNT, 16'hFFFF, "R7");
        drain();
        cnt_pin = 1'b1;
        expect_in(6, SIG_CNT, 16'hFFFF, "R7");
        drain();
        cnt_pin = 1'b0;
        expect_in(3, SIG_CNT, 16'h0000, "R6");
        expect_in(3, SIG_OVF, 16'h1, "R6");
        expect_in(3, SIG_HOLD, 16'h1111, "R6");
        drain();
        cnt_pin = 1'b1;
        idle(4);
        wr(A_FLG, 8'h00);

        // R12 count byte write beats a same-edge step
        set_cnt(16'h0200);
        cnt_pin = 1'b0;
        expect_in(3, SIG_CNT, 16'h0210, "R12");
        idle(2);
        wr(A_CLO, 8'h10);
        drain();
        cnt_pin = 1'b1;
        idle(4);
        wr(A_CTL, 8'h00);

        // R8 capture on trigger
        osc_tick = 1'b0;
        set_cnt(16'h5A5A);
        wr(A_CTL, C_RUN | C_CAP | C_TRG);
        trig_pin = 1'b0;
        expect_in(2, SIG_HOLD, 16'h1111, "R8");
        expect_in(2, SIG_TRIG, 16'h0, "R8");
        expect_in(3, SIG_HOLD, 16'h5A5A, "R8");
        expect_in(3, SIG_TRIG, 16'h1, "R8");
        expect_in(3, SIG_CNT, 16'h5A5A, "R8");
        drain();
        trig_pin = 1'b1;
        idle(4);
        wr(A_FLG, 8'h00);

        // R9 reload on trigger
        set_cnt(16'h0100);
        set_hold(16'h7777);
        wr(A_CTL, C_RUN | C_TRG);
        trig_pin = 1'b0;
        expect_in(3, SIG_CNT, 16'h7777, "R9");
        expect_in(3, SIG_TRIG, 16'h1, "R9");
        drain();
        trig_pin = 1'b1;
        idle(4);
        wr(A_FLG, 8'h00);

        // R10 trigger ignored: enable clear, baud mode, halted
        set_cnt(16'h0042);
        set_hold(16'h9999);
        wr(A_CTL, C_RUN);
        trig_pin = 1'b0;
        expect_in(5, SIG_CNT, 16'h0042, "R10");
        expect_in(5, SIG_TRIG, 16'h0, "R10");
        drain();
        trig_pin = 1'b1;
        idle(4);
        wr(A_CTL, C_RUN | C_TXB | C_TRG);
        trig_pin = 1'b0;
        expect_in(5, SIG_CNT, 16'h0042, "R10");
        expect_in(5, SIG_HOLD, 16'h9999, "R10");
        expect_in(5, SIG_TRIG, 16'h0, "R10");
        drain();
        trig_pin = 1'b1;
        idle(4);
        wr(A_CTL, C_CAP | C_TRG);
        trig_pin = 1'b0;
        expect_in(5, SIG_HOLD, 16'h9999, "R10");
        expect_in(5, SIG_TRIG, 16'h0, "R10");
        drain();
        trig_pin = 1'b1;
        idle(4);

        // R13 flag register write sets both flags directly
        expect_in(1, SIG_OVF, 16'h1, "R13");
        expect_in(1, SIG_TRIG, 16'h1, "R13");
        wr(A_FLG, 8'h03);
        drain();

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule